// File: doc/BRIEF.md
# Interleaved Partial-Sum Dot-Product Accumulator

This block forms the dot product of one row by taking one pair of signed operands per clock. Each product goes into a rotating bank of partial sums, one slot per cycle of adder latency. A new product is therefore always added to a sum whose previous update was many cycles earlier. A deep, pipelined adder can then sit in the accumulation loop, and the stream still never has to stall.

A row holds a fixed number of pairs. A start pulse opens the row and clears the bank. When the final pair of the row is accepted, the block copies the whole bank into a snapshot register. A pipelined adder tree reduces that snapshot to one result, which the block presents with a single-cycle strobe. Because the tree works on its own copy, the next row can start filling the bank in the very next cycle. Results therefore leave in row order, one per row.

Top module: `dotRowAccumulator`

## Requirements
- R1: After reset, `resValid` is low and `resData` is zero until a row completes.
- R2: For a row of ROW_LEN (default 64) accepted pairs, `resData` equals the signed sum of `inA*inB` over that row, where both operands are two's-complement.
- R3: `resValid` is observed high in the clock cycle that follows the fourth rising edge after the edge that accepts the last pair of the row. This holds for the default LAT of 16, where the tree depth is log2(LAT) = 4.
- R4: Cycles with `inValid` low inside a row leave the partial sums untouched, so a row fed with gaps yields the same result as one fed without gaps.
- R5: Pairs presented while no row is open are ignored. This covers pairs after reset and before any start pulse, and pairs after a row's last pair before the next start pulse. Such pairs never produce a result.
- R6: A start pulse clears the partial sums and discards any unfinished row. If `inValid` is high in the same cycle as the pulse, that pair is the row's first element. A pulse with `inValid` low opens an empty row.
- R7: A start pulse in the cycle right after a row's last pair begins the next row while the previous row is still being reduced. Both results appear, in row order, each with its own latency from R3.
- R8: Full-scale operands cannot overflow. 64 products of -32768 by -32768 give 2^36, and 64 products of -32768 by 32767 give -68717379584.
- R9: Each completed row raises `resValid` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rowStart | input | 1 | Single-cycle pulse that opens a new row |
| inValid | input | 1 | Qualifies the operand pair |
| inA | input | DATA_W | Signed operand A |
| inB | input | DATA_W | Signed operand B |
| resValid | output | 1 | One-cycle strobe for a row result |
| resData | output | ACC_W | Signed row dot product |

## Verification
A slot that rotates wrongly, or a gap cycle that shifts the bank, does not stop the block from producing a result. Either fault shows only as a wrong `resData` value. It surfaces at the strobe of the same row, four cycles after that row's last pair. A row counter that is off by one shows as a strobe that comes too early or too late, or that is missing or doubled. Rows run back to back with gaps, and runs of stray pairs, expose these counter faults within one row. A snapshot that is taken too late mixes the next row's first product into the previous result. This is why rows are also run back to back.

// File: rtl/dotacc_pkg.sv
`timescale 1ns/1ps
package dotacc_pkg;
  // Strobes from the row sequencer to the accumulation datapath
  typedef struct packed {
    logic clear;   // start of row: zero the bank before this cycle's update
    logic accept;  // an operand pair enters the bank this cycle
    logic last;    // this accepted pair completes the row
  } accStrobe_t;
endpackage

// File: rtl/rowSequencer.sv
`timescale 1ns/1ps
module rowSequencer
  import dotacc_pkg::*;
#(
  parameter int ROW_LEN = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rowStart,
  input  logic       inValid,
  output accStrobe_t strobe
);
  localparam int CNT_W = $clog2(ROW_LEN + 1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] countBase;
  logic             active;

  always_comb begin
    countBase     = rowStart ? '0 : count;
    strobe.clear  = rowStart;
    strobe.accept = inValid && (rowStart || active);
    strobe.last   = strobe.accept && (countBase == CNT_W'(ROW_LEN - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      active <= 1'b0;
    end else begin
      active <= (rowStart || active) && !strobe.last;
      if (strobe.accept)
        count <= strobe.last ? '0 : CNT_W'(countBase + 1'b1);
      else
        count <= countBase;
    end
  end

  // R2: the pair index never leaves the row
  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    count < CNT_W'(ROW_LEN));

  // R5: with no row open the position stays parked at zero
  assert_idle_parked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !rowStart) |=> (count == '0));

  // R9: completing a row closes it
  assert_row_closes_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.last |=> !active);
endmodule

// File: rtl/accumulatorPath.sv
`timescale 1ns/1ps
module accumulatorPath
  import dotacc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int LAT    = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  accStrobe_t               strobe,
  input  logic signed [DATA_W-1:0] inA,
  input  logic signed [DATA_W-1:0] inB,
  output logic                     resValid,
  output logic signed [ACC_W-1:0]  resData
);
  localparam int LEVELS = $clog2(LAT);
  localparam int TREE_N = 1 << LEVELS;
  localparam int PROD_W = 2 * DATA_W;

  // Rotating partial-sum bank: slot 0 is the oldest, slot LAT-1 the newest
  logic [LAT-1:0][ACC_W-1:0] slots;
  logic [LAT-1:0][ACC_W-1:0] slotsBase;
  logic [LAT-1:0][ACC_W-1:0] slotsNext;
  logic signed [PROD_W-1:0]  prod;
  logic [ACC_W-1:0]          prodExt;

  always_comb begin
    prod      = inA * inB;
    prodExt   = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
    slotsBase = strobe.clear ? '0 : slots;
    slotsNext = slotsBase;
    if (strobe.accept) begin
      for (int i = 0; i < LAT - 1; i++)
        slotsNext[i] = slotsBase[i+1];
      slotsNext[LAT-1] = slotsBase[0] + prodExt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slots <= '0;
    else       slots <= slotsNext;
  end

  // Snapshot padded to a power of two, then a heap-indexed pipelined tree:
  // node n sums nodes 2n and 2n+1, leaves sit at TREE_N..2*TREE_N-1, root is 1
  logic [TREE_N-1:0][ACC_W-1:0]   padded;
  logic [2*TREE_N-1:1][ACC_W-1:0] heap;
  logic [LEVELS:0]                validPipe;

  always_comb begin
    padded          = '0;
    padded[LAT-1:0] = slotsNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heap      <= '0;
      validPipe <= '0;
    end else begin
      if (strobe.last)
        for (int k = 0; k < TREE_N; k++) heap[TREE_N + k] <= padded[k];
      for (int n = 1; n < TREE_N; n++)
        heap[n] <= heap[2*n] + heap[2*n+1];
      validPipe <= {validPipe[LEVELS-1:0], strobe.last};
    end
  end

  assign resData  = $signed(heap[1]);
  assign resValid = validPipe[LEVELS];

  // R4: a cycle without a pair or a start leaves the bank untouched
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.accept && !strobe.clear) |=> $stable(slots));

  // R6: a bare start pulse empties the bank
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clear && !strobe.accept) |=> (slots == '0));

  // R3: every strobe traces back to a row end a fixed tree depth earlier
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(strobe.last, LEVELS + 1));

  // R9: the result strobe lasts one cycle
  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);
endmodule

// File: rtl/dotRowAccumulator.sv
`timescale 1ns/1ps
module dotRowAccumulator
  import dotacc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ACC_W   = 40,
  parameter int ROW_LEN = 64,
  parameter int LAT     = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rowStart,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inA,
  input  logic signed [DATA_W-1:0] inB,
  output logic                     resValid,
  output logic signed [ACC_W-1:0]  resData
);
  accStrobe_t strobe;

  rowSequencer #(.ROW_LEN(ROW_LEN)) i_rowSequencer (
    .clk      (clk),
    .rstN     (rstN),
    .rowStart (rowStart),
    .inValid  (inValid),
    .strobe   (strobe)
  );

  accumulatorPath #(.DATA_W(DATA_W), .ACC_W(ACC_W), .LAT(LAT)) i_accumulatorPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inA      (inA),
    .inB      (inB),
    .resValid (resValid),
    .resData  (resData)
  );
endmodule

// File: tb/test_dotRowAccumulator.sv
`timescale 1ns/1ps
module test_dotRowAccumulator;
  localparam int ROW = 64;
  localparam int LVL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rowStart = 1'b0;
  logic inValid = 1'b0;
  logic signed [15:0] inA = '0;
  logic signed [15:0] inB = '0;
  logic resValid;
  logic signed [39:0] resData;

  dotRowAccumulator i_dotRowAccumulator (
    .clk(clk), .rstN(rstN), .rowStart(rowStart), .inValid(inValid),
    .inA(inA), .inB(inB), .resValid(resValid), .resData(resData)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint capData [32];
  int     capCyc  [32];
  int     capN = 0;
  always @(negedge clk) begin
    if (resValid) begin
      if (capN < 32) begin
        capData[capN] = longint'(resData);
        capCyc[capN]  = cyc;
      end
      capN++;
    end
  end

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      rowStart = 1'b0;
      inValid  = 1'b0;
    end
  endtask

  // kind 0 random, 1 min*min, 2 min*max, 3 small ramp
  task automatic feedRow(input int nPairs, input int gapMax, input int startMode,
                         input int kind, output longint expv, output int lastE);
    expv  = 0;
    lastE = 0;
    if (startMode == 2) begin
      @(negedge clk);
      rowStart = 1'b1;
      inValid  = 1'b0;
    end
    for (int i = 0; i < nPairs; i++) begin
      logic signed [15:0] a;
      logic signed [15:0] b;
      if (i > 0 && gapMax > 0) begin
        int g;
        g = $urandom_range(gapMax, 0);
        repeat (g) begin
          @(negedge clk);
          rowStart = 1'b0;
          inValid  = 1'b0;
        end
      end
      case (kind)
        1: begin a = -16'sd32768; b = -16'sd32768; end
        2: begin a = -16'sd32768; b = 16'sd32767; end
        3: begin a = 16'(i - 20); b = 16'(3 - (i % 7)); end
        default: begin a = 16'($urandom); b = 16'($urandom); end
      endcase
      @(negedge clk);
      rowStart = (i == 0 && startMode == 1);
      inValid  = 1'b1;
      inA = a;
      inB = b;
      expv += longint'(a) * longint'(b);
      lastE = cyc + 1;
    end
  endtask

  task automatic oneRow(input int gapMax, input int startMode, input int kind,
                        input string req);
    longint e;
    int le;
    int base;
    base = capN;
    feedRow(ROW, gapMax, startMode, kind, e, le);
    idle(LVL + 6);
    chk(capN - base == 1, "R9", capN - base, 1);
    if (capN - base >= 1) begin
      chk(capData[base] == e, req, capData[base], e);
      chk(capCyc[base] - le == LVL, "R3", capCyc[base] - le, LVL);
    end
  endtask

  task automatic t_reset;
    idle(5);
    chk(resValid == 1'b0, "R1", resValid, 0);
    chk(resData == '0, "R1", resData, 0);
  endtask

  task automatic t_basic;
    oneRow(0, 1, 0, "R2");
    oneRow(0, 1, 3, "R2");
  endtask

  task automatic t_gaps;
    oneRow(3, 1, 0, "R4");
    oneRow(5, 1, 0, "R4");
  endtask

  task automatic t_fullscale;
    oneRow(0, 1, 1, "R8");
    oneRow(2, 1, 2, "R8");
  endtask

  task automatic t_ignore;
    int base;
    base = capN;
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      rowStart = 1'b0;
      inValid  = 1'b1;
      inA = 16'sd1000;
      inB = 16'sd1000;
    end
    idle(LVL + 6);
    chk(capN == base, "R5", capN - base, 0);
    oneRow(1, 2, 0, "R5");
  endtask

  task automatic t_restart;
    longint e;
    int le;
    int base;
    base = capN;
    feedRow(30, 1, 1, 0, e, le);
    feedRow(ROW, 1, 1, 0, e, le);
    idle(LVL + 6);
    chk(capN - base == 1, "R6", capN - base, 1);
    if (capN - base >= 1) chk(capData[base] == e, "R6", capData[base], e);
    oneRow(0, 2, 3, "R6");
  endtask

  task automatic t_backToBack;
    longint e [3];
    int le [3];
    int base;
    base = capN;
    for (int r = 0; r < 3; r++) feedRow(ROW, 0, 1, 0, e[r], le[r]);
    idle(LVL + 6);
    chk(capN - base == 3, "R7", capN - base, 3);
    if (capN - base >= 3) begin
      for (int r = 0; r < 3; r++) begin
        chk(capData[base + r] == e[r], "R7", capData[base + r], e[r]);
        chk(capCyc[base + r] - le[r] == LVL, "R7", capCyc[base + r] - le[r], LVL);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ignore();
    t_basic();
    t_gaps();
    t_fullscale();
    t_restart();
    t_backToBack();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule